// File: doc/BRIEF.md
# Cascadable Gated Timer Pair

This block holds two up-counting timers that share one external gate pin. Each timer is clocked by one of four tick sources: every system clock, a divide-by-16 enable supplied from outside, rising edges on its own input pin, or the reference-match pulse of the other timer. When a tick arrives while the count equals the timer's reference value, the count returns to zero. A reference event is flagged, and the timer's output pin either drops low for one clock or flips level. Edges on the same input pin can copy the running count into a capture register.

The gate pin serves either timer or both. It either pauses counting while it is high, or clears the count on its falling edge. Setting the cascade bit joins the two counters into one 32-bit counter. The first timer's tick source and gate assignment then drive the joined counter, both reference registers form the 32-bit terminal value, and only the second timer's output pin reports matches. Software reaches the block through a single-cycle register write port with a combinational read-back. Sticky event flags are cleared by writing ones.

Top module: `gated_timer_pair`

## Requirements
- R1: After reset both output pins are high, all event flags are 0, and every register reads 0.
- R2: Control field src (bits 1:0) selects the tick source: 0 = every clock, 1 = div16_en, 2 = rising edge of the timer's own synchronized pin, 3 = the other timer's reference match, delayed one cycle. Control bit 5 enables counting.
- R3: On a tick, the counter increments, or returns to 0 if it equals the reference value (timer n reference at address 4n+1, count at 4n+3). That match sets flag bit 0 for timer 0 or bit 2 for timer 1.
- R4: With control bit 4 clear, each reference match drives the output pin low for exactly the next clock cycle.
- R5: With control bit 4 set, each reference match flips the output pin once, and the pin holds its level otherwise.
- R6: Control bits 3:2 select the capture edges: bit 2 = rising, bit 3 = falling, both = either. A selected edge copies the count into the capture register (address 4n+2) and sets flag bit 1 (timer 0) or bit 3 (timer 1). Unselected edges have no effect.
- R7: The flags (address 9) are sticky. Writing 1 to a bit clears it. A new event in the same cycle wins over the clear.
- R8: With global bit 1 clear (gate mode), an assigned timer does not count while the synchronized gate is high.
- R9: With global bit 1 set (restart mode), a falling edge of the synchronized gate clears an assigned timer's count to 0, and counting continues.
- R10: Global bit 2 assigns the gate to timer 0 and bit 3 assigns it to timer 1. An unassigned timer ignores the gate.
- R11: With global bit 0 set (cascade), the counts form one 32-bit counter with terminal value {ref1, ref0}, clocked and gated as timer 0. Only output pin 1 and flag bit 2 report its matches. Output pin 0 stays high in pulse mode.
- R12: Input pins and the gate pass through two synchronizing flops. A pin change that is set up before clock edge k acts on the counter at edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div16_en | input | 1 | One-cycle enable from the divided system clock |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Combinational read data for reg_addr |
| tmr_pin_i | input | 2 | Timer input pins (tick source and capture) |
| gate_i | input | 1 | Shared gate pin |
| tout_o | output | 2 | Timer output pins |
| evt_flags_o | output | 4 | Sticky event flags {cap1, ref1, cap0, ref0} |

## Verification
The hardest state to reach from the ports is a cascaded match. It needs the low half to wrap through all 65536 values before the high half advances. A directed run with terminal value 0x00010002 on the every-clock source drives one full 32-bit period and counts the low pulses on both output pins. The cross-timer tick source is also hard to reach. So are gate edges that land on the same cycle as a match or a capture. For these, long constrained-random runs use small reference values and frequent pin and gate toggles, and compare against a cycle-level model in the bench.

// File: rtl/gtp_pkg.sv
package gtp_pkg;

    typedef enum logic [1:0] {
        SRC_SYS  = 2'd0,
        SRC_DIV  = 2'd1,
        SRC_PIN  = 2'd2,
        SRC_PEER = 2'd3
    } src_e;

    // per-timer control word, bit 5 down to bit 0
    typedef struct packed {
        logic       run;
        logic       toggle;
        logic [1:0] cap_edge;   // [0] rising, [1] falling
        src_e       src;
    } ctrl_t;

    // shared control word, bit 3 down to bit 0
    typedef struct packed {
        logic gate_t1;
        logic gate_t0;
        logic restart;
        logic cascade;
    } glob_t;

    localparam int          CTRL_W  = $bits(ctrl_t);
    localparam int          GLOB_W  = $bits(glob_t);
    localparam logic [3:0]  A_GLOB  = 4'd8;
    localparam logic [3:0]  A_FLAGS = 4'd9;
    localparam logic [1:0]  F_CTRL  = 2'd0;
    localparam logic [1:0]  F_REF   = 2'd1;
    localparam logic [1:0]  F_CAP   = 2'd2;
    localparam logic [1:0]  F_CNT   = 2'd3;

endpackage

// File: rtl/gtp_edge_sync.sv
module gtp_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int SH_W = STAGES + 1;

    logic [SH_W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[SH_W-2:0], pin_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign level_o = sh_q[STAGES-1];
    assign rise_o  = sh_q[STAGES-1] & ~sh_q[STAGES];
    assign fall_o  = ~sh_q[STAGES-1] & sh_q[STAGES];

    // R12: a synchronized edge reflects the pin as it was STAGES edges ago
    p_sync_delay_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |-> $past(pin_i, 2))
        else $error("p_sync_delay_r12");

endmodule

// File: rtl/gtp_count_unit.sv
module gtp_count_unit #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic         inc,
    input  logic         wrap,
    output logic [W-1:0] cnt_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (restart)   cnt_d = '0;
        else if (inc)  cnt_d = wrap ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    p_count_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !wrap && !restart) |=> (cnt_o == $past(cnt_o) + 1'b1))
        else $error("p_count_up_r3");

    p_wrap_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && wrap) |=> (cnt_o == '0))
        else $error("p_wrap_zero_r3");

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !restart) |=> $stable(cnt_o))
        else $error("p_hold_r8");

    p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt_o == '0))
        else $error("p_restart_r9");

endmodule

// File: rtl/gtp_pin_out.sv
module gtp_pin_out (
    input  logic clk,
    input  logic rst_n,
    input  logic toggle_mode,
    input  logic match,
    output logic pin_o
);
    logic pin_d, pin_q;

    always_comb begin
        if (toggle_mode) pin_d = pin_q ^ match;
        else             pin_d = ~match;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_q <= 1'b1;
        else        pin_q <= pin_d;
    end

    assign pin_o = pin_q;

    p_pulse_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!toggle_mode && match) |=> !pin_o)
        else $error("p_pulse_low_r4");

    p_pulse_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!toggle_mode && !match) |=> pin_o)
        else $error("p_pulse_idle_r4");

    p_toggle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (toggle_mode && !match) |=> $stable(pin_o))
        else $error("p_toggle_hold_r5");

endmodule

// File: rtl/gated_timer_pair.sv
module gated_timer_pair
    import gtp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             div16_en,
    input  logic             reg_we,
    input  logic [3:0]       reg_addr,
    input  logic [CNT_W-1:0] reg_wdata,
    output logic [CNT_W-1:0] reg_rdata,
    input  logic [1:0]       tmr_pin_i,
    input  logic             gate_i,
    output logic [1:0]       tout_o,
    output logic [3:0]       evt_flags_o
);
    localparam int N_TMR   = 2;
    localparam int N_FLAGS = 2 * N_TMR;

    typedef struct packed {
        ctrl_t [N_TMR-1:0]            ctrl;
        logic  [N_TMR-1:0][CNT_W-1:0] refv;
        logic  [N_TMR-1:0][CNT_W-1:0] cap;
        logic  [N_FLAGS-1:0]          flags;
        glob_t                        glob;
        logic  [N_TMR-1:0]            mpulse;
    } regs_t;

    regs_t st_d, st_q;

    logic [N_TMR-1:0]            pin_rise, pin_fall, pin_lvl;
    logic                        gate_lvl, gate_rise, gate_fall;
    logic [N_TMR-1:0]            src_tick, tick, rst_ev, inc, wrap, rs, match, capevt, gate_asg;
    logic [N_TMR-1:0][CNT_W-1:0] cnt;
    logic                        full;
    logic [N_FLAGS-1:0]          clr_mask;

    genvar g;
    generate
        for (g = 0; g < N_TMR; g++) begin : g_tmr
            gtp_edge_sync #(.STAGES(2)) u_pin_sync (
                .clk(clk), .rst_n(rst_n), .pin_i(tmr_pin_i[g]),
                .level_o(pin_lvl[g]), .rise_o(pin_rise[g]), .fall_o(pin_fall[g]));
            gtp_count_unit #(.W(CNT_W)) u_cnt (
                .clk(clk), .rst_n(rst_n), .restart(rs[g]), .inc(inc[g]),
                .wrap(wrap[g]), .cnt_o(cnt[g]));
            gtp_pin_out u_out (
                .clk(clk), .rst_n(rst_n), .toggle_mode(st_q.ctrl[g].toggle),
                .match(match[g]), .pin_o(tout_o[g]));
        end
    endgenerate

    gtp_edge_sync #(.STAGES(2)) u_gate_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(gate_i),
        .level_o(gate_lvl), .rise_o(gate_rise), .fall_o(gate_fall));

    assign gate_asg = {st_q.glob.gate_t1, st_q.glob.gate_t0};
    assign full     = ({cnt[1], cnt[0]} == {st_q.refv[1], st_q.refv[0]});
    assign clr_mask = (reg_we && reg_addr == A_FLAGS) ? reg_wdata[N_FLAGS-1:0] : '0;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N_TMR; i++) begin
            case (st_q.ctrl[i].src)
                SRC_SYS:  src_tick[i] = 1'b1;
                SRC_DIV:  src_tick[i] = div16_en;
                SRC_PIN:  src_tick[i] = pin_rise[i];
                default:  src_tick[i] = st_q.mpulse[N_TMR-1-i];
            endcase
            tick[i]   = st_q.ctrl[i].run && src_tick[i] &&
                        !(!st_q.glob.restart && gate_lvl && gate_asg[i]);
            rst_ev[i] = st_q.glob.restart && gate_fall && gate_asg[i];
            capevt[i] = (st_q.ctrl[i].cap_edge[0] && pin_rise[i]) ||
                        (st_q.ctrl[i].cap_edge[1] && pin_fall[i]);
        end

        if (st_q.glob.cascade) begin
            inc   = {tick[0] && (full || (&cnt[0])), tick[0]};
            wrap  = {full, full};
            rs    = {rst_ev[0], rst_ev[0]};
            match = {tick[0] && full, 1'b0};
        end else begin
            inc = tick;
            rs  = rst_ev;
            for (int i = 0; i < N_TMR; i++) begin
                wrap[i]  = (cnt[i] == st_q.refv[i]);
                match[i] = tick[i] && wrap[i];
            end
        end

        for (int i = 0; i < N_TMR; i++) begin
            if (capevt[i]) st_d.cap[i] = cnt[i];
        end
        st_d.mpulse = match;
        st_d.flags  = (st_q.flags & ~clr_mask) | {capevt[1], match[1], capevt[0], match[0]};

        if (reg_we) begin
            if (!reg_addr[3]) begin
                if (reg_addr[1:0] == F_CTRL) st_d.ctrl[reg_addr[2]] = ctrl_t'(reg_wdata[CTRL_W-1:0]);
                if (reg_addr[1:0] == F_REF)  st_d.refv[reg_addr[2]] = reg_wdata;
            end else if (reg_addr == A_GLOB) begin
                st_d.glob = glob_t'(reg_wdata[GLOB_W-1:0]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        if (!reg_addr[3]) begin
            case (reg_addr[1:0])
                F_CTRL:  reg_rdata = CNT_W'(st_q.ctrl[reg_addr[2]]);
                F_REF:   reg_rdata = st_q.refv[reg_addr[2]];
                F_CAP:   reg_rdata = st_q.cap[reg_addr[2]];
                default: reg_rdata = cnt[reg_addr[2]];
            endcase
        end else if (reg_addr == A_GLOB) begin
            reg_rdata = CNT_W'(st_q.glob);
        end else if (reg_addr == A_FLAGS) begin
            reg_rdata = CNT_W'(st_q.flags);
        end
    end

    assign evt_flags_o = st_q.flags;

    // R7: a set flag stays set unless a write-1 clear hit it
    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((~st_q.flags & $past(st_q.flags & ~clr_mask)) == '0))
        else $error("p_flag_sticky_r7");

    p_cascade_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.glob.cascade && !st_q.ctrl[0].toggle) |=> tout_o[0])
        else $error("p_cascade_quiet_r11");

endmodule

// File: tb/gated_timer_pair_tb_top.sv
module gated_timer_pair_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        div16_en = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [1:0]  tmr_pin_i = '0;
    logic        gate_i = 1'b0;
    logic [1:0]  tout_o;
    logic [3:0]  evt_flags_o;

    int n_chk = 0;
    int n_fail = 0;
    int divc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gated_timer_pair #(.CNT_W(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .div16_en(div16_en), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tmr_pin_i(tmr_pin_i), .gate_i(gate_i), .tout_o(tout_o),
        .evt_flags_o(evt_flags_o));

    // ---------------- cycle-level reference model ----------------
    logic [5:0]  m_ctrl [2];
    logic [15:0] m_ref [2];
    logic [15:0] m_cnt [2];
    logic [15:0] m_cap [2];
    logic [2:0]  m_ps [2];
    logic [2:0]  m_gs;
    logic [3:0]  m_flags, m_glob;
    logic [1:0]  m_tout, m_mp;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 2; i++) begin
                m_ctrl[i] = '0; m_ref[i] = '0; m_cnt[i] = '0; m_cap[i] = '0; m_ps[i] = '0;
            end
            m_gs = '0; m_flags = '0; m_glob = '0; m_tout = 2'b11; m_mp = '0;
        end else begin
            logic [1:0]  rise, fall, tk, rsv, mt, ce, hit;
            logic [15:0] nc [2];
            logic        gfall, full, s;
            gfall = ~m_gs[1] & m_gs[2];
            for (int i = 0; i < 2; i++) begin
                rise[i] = m_ps[i][1] & ~m_ps[i][2];
                fall[i] = ~m_ps[i][1] & m_ps[i][2];
                case (m_ctrl[i][1:0])
                    2'd0: s = 1'b1;
                    2'd1: s = div16_en;
                    2'd2: s = rise[i];
                    default: s = m_mp[1-i];
                endcase
                tk[i]  = m_ctrl[i][5] & s & ~(~m_glob[1] & m_gs[1] & m_glob[2+i]);
                rsv[i] = m_glob[1] & gfall & m_glob[2+i];
                ce[i]  = (m_ctrl[i][2] & rise[i]) | (m_ctrl[i][3] & fall[i]);
            end
            if (m_glob[0]) begin
                full  = ({m_cnt[1], m_cnt[0]} == {m_ref[1], m_ref[0]});
                mt    = {tk[0] & full, 1'b0};
                nc[0] = rsv[0] ? 16'd0 : tk[0] ? (full ? 16'd0 : m_cnt[0] + 16'd1) : m_cnt[0];
                nc[1] = rsv[0] ? 16'd0 : tk[0] ? (full ? 16'd0 :
                        (m_cnt[0] == 16'hFFFF ? m_cnt[1] + 16'd1 : m_cnt[1])) : m_cnt[1];
            end else begin
                for (int i = 0; i < 2; i++) begin
                    hit[i] = (m_cnt[i] == m_ref[i]);
                    mt[i]  = tk[i] & hit[i];
                    nc[i]  = rsv[i] ? 16'd0 : tk[i] ? (hit[i] ? 16'd0 : m_cnt[i] + 16'd1) : m_cnt[i];
                end
            end
            for (int i = 0; i < 2; i++) begin
                if (ce[i]) m_cap[i] = m_cnt[i];
                m_tout[i] = m_ctrl[i][4] ? (m_tout[i] ^ mt[i]) : ~mt[i];
                m_cnt[i]  = nc[i];
                m_ps[i]   = {m_ps[i][1:0], tmr_pin_i[i]};
            end
            m_flags = (m_flags & ~((reg_we && reg_addr == 4'd9) ? reg_wdata[3:0] : 4'd0))
                      | {ce[1], mt[1], ce[0], mt[0]};
            m_mp = mt;
            m_gs = {m_gs[1:0], gate_i};
            if (reg_we) begin
                if (!reg_addr[3] && reg_addr[1:0] == 2'd0) m_ctrl[reg_addr[2]] = reg_wdata[5:0];
                if (!reg_addr[3] && reg_addr[1:0] == 2'd1) m_ref[reg_addr[2]]  = reg_wdata;
                if (reg_addr == 4'd8) m_glob = reg_wdata[3:0];
            end
        end
    end

    function automatic logic [15:0] m_read(input logic [3:0] a);
        if (!a[3]) begin
            case (a[1:0])
                2'd0: return {10'd0, m_ctrl[a[2]]};
                2'd1: return m_ref[a[2]];
                2'd2: return m_cap[a[2]];
                default: return m_cnt[a[2]];
            endcase
        end
        if (a == 4'd8) return {12'd0, m_glob};
        if (a == 4'd9) return {12'd0, m_flags};
        return 16'd0;
    endfunction

    // ---------------- helpers ----------------
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic cyc(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; tmr_pin_i = '0; gate_i = 1'b0; reg_we = 1'b0;
        cyc(2);
        rst_n = 1'b1;
    endtask

    // divided-clock enable: one cycle in 16
    always @(negedge clk) begin
        divc = (divc + 1) % 16;
        div16_en = (divc == 15);
    end

    // continuous comparison of pins and flags (R3 R4 R5 R6 R7 R11)
    always @(negedge clk) begin
        if (rst_n) begin
            #2;
            chk("R4/R5/R11 tout vs model", {30'd0, tout_o}, {30'd0, m_tout});
            chk("R3/R6/R7 flags vs model", {28'd0, evt_flags_o}, {28'd0, m_flags});
        end
    end

    initial begin
        #(CLK_PERIOD * 190000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        report();
    end

    initial begin
        logic [15:0] a0, a1, b0, b1, v;
        int lows, edges;
        logic prev;
        void'($urandom(32'd2718));

        // R1 reset state
        cyc(2);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 tout after reset", {30'd0, tout_o}, 32'd3);
        chk("R1 flags after reset", {28'd0, evt_flags_o}, 32'd0);
        for (int a = 0; a < 10; a++) begin
            rd(a[3:0], v);
            chk("R1 register reads zero", {16'd0, v}, 32'd0);
        end

        // R4 pulse mode: ref 4 -> period 5, one low cycle each
        wr(4'd1, 16'd4);
        wr(4'd0, 16'h0020);
        cyc(10);
        lows = 0;
        for (int k = 0; k < 50; k++) begin
            @(negedge clk); #3;
            if (!tout_o[0]) lows++;
        end
        chk("R4 low cycles in 50", lows, 32'd10);

        // R5 toggle mode
        wr(4'd0, 16'h0030);
        cyc(10);
        edges = 0; prev = tout_o[0];
        for (int k = 0; k < 50; k++) begin
            @(negedge clk); #3;
            if (tout_o[0] != prev) edges++;
            prev = tout_o[0];
        end
        chk("R5 flips in 50", edges, 32'd10);

        // R12 sync latency on pin tick source
        do_reset();
        wr(4'd1, 16'hFFFF);
        wr(4'd0, 16'h0022);
        tmr_pin_i[0] = 1'b1;
        @(negedge clk); rd(4'd3, v); chk("R12 no tick after 1 edge", v, 32'd0);
        @(negedge clk); rd(4'd3, v); chk("R12 no tick after 2 edges", v, 32'd0);
        @(negedge clk); rd(4'd3, v); chk("R2 R12 tick after 3 edges", v, 32'd1);

        // R6 falling-only capture, R7 write-1 clear
        wr(4'd0, 16'h002A);
        tmr_pin_i[0] = 1'b0;
        cyc(2);  #2; chk("R6 capture not yet", evt_flags_o[1], 32'd0);
        cyc(1);  #2; chk("R6 capture on fall", evt_flags_o[1], 32'd1);
        wr(4'd9, 16'h0002);
        #2; chk("R7 clear by writing 1", evt_flags_o[1], 32'd0);
        tmr_pin_i[0] = 1'b1;
        cyc(4); #2; chk("R6 rising edge ignored", evt_flags_o[1], 32'd0);

        // R2 divided-clock source
        do_reset();
        wr(4'd1, 16'hFFFF);
        wr(4'd0, 16'h0021);
        cyc(3);
        rd(4'd3, a0); cyc(160); rd(4'd3, b0);
        chk("R2 div16 ticks in 160", b0 - a0, 32'd10);

        // R8 R10 gate assigned to timer 1 only, gated mode
        do_reset();
        wr(4'd1, 16'hFFFF); wr(4'd5, 16'hFFFF);
        wr(4'd8, 16'h0008);
        wr(4'd0, 16'h0020); wr(4'd4, 16'h0020);
        gate_i = 1'b1;
        cyc(4);
        rd(4'd3, a0); rd(4'd7, a1);
        cyc(20);
        rd(4'd3, b0); rd(4'd7, b1);
        chk("R10 unassigned timer ignores gate", b0 - a0, 32'd20);
        chk("R8 gated timer holds", b1, a1);

        // R9 restart on gate fall, timer 0 assigned
        wr(4'd8, 16'h0006);
        cyc(5);
        gate_i = 1'b0;
        cyc(3);
        rd(4'd3, v); chk("R9 restart clears count", v, 32'd0);
        cyc(1);
        rd(4'd3, v); chk("R9 counting continues", v, 32'd1);

        // constrained random against the model (R2 R3 R6 R8 R9 R10 R11)
        do_reset();
        for (int k = 0; k < 30000; k++) begin
            logic [3:0] ra;
            logic [15:0] expv;
            int sel;
            @(negedge clk);
            if ($urandom_range(7) == 0) tmr_pin_i[0] = ~tmr_pin_i[0];
            if ($urandom_range(7) == 0) tmr_pin_i[1] = ~tmr_pin_i[1];
            if ($urandom_range(15) == 0) gate_i = ~gate_i;
            ra = 4'($urandom_range(9));
            rd(ra, v);
            expv = m_read(ra);
            chk("R2/R3/R6/R9 register vs model", v, expv);
            reg_we = 1'b0;
            if ($urandom_range(15) == 0) begin
                sel = $urandom_range(5);
                reg_we = 1'b1;
                case (sel)
                    0: begin reg_addr = 4'd0; reg_wdata = 16'($urandom_range(63)); end
                    1: begin reg_addr = 4'd4; reg_wdata = 16'($urandom_range(63)); end
                    2: begin reg_addr = 4'd1; reg_wdata = 16'($urandom_range(15)); end
                    3: begin reg_addr = 4'd5; reg_wdata = 16'($urandom_range(15)); end
                    4: begin reg_addr = 4'd8; reg_wdata = 16'($urandom_range(15)); end
                    default: begin reg_addr = 4'd9; reg_wdata = 16'($urandom_range(15)); end
                endcase
            end
        end
        @(negedge clk); reg_we = 1'b0;

        // R11 cascade: terminal 0x0001_0002 on every-clock source
        do_reset();
        wr(4'd1, 16'd2); wr(4'd5, 16'd1);
        wr(4'd8, 16'h0001);
        wr(4'd0, 16'h0020);
        lows = 0; edges = 0;
        for (int k = 0; k < 70000; k++) begin
            @(negedge clk); #3;
            if (!tout_o[1]) lows++;
            if (!tout_o[0]) edges++;
        end
        chk("R11 one 32-bit match on tout1", lows, 32'd1);
        chk("R11 tout0 silent in cascade", edges, 32'd0);
        rd(4'd7, v);
        chk("R11 high half after wrap", v, 32'd0);

        report();
    end

endmodule